// File: doc/BRIEF.md
# Frequency Lock Detector with Hysteresis

This block decides whether a divided feedback clock runs at the same frequency as a divided reference clock. It reports the answer as a lock status bit. Software can read this bit but cannot write it. The block sees both clocks as single-cycle edge pulses that are already synchronous to a fast system clock. A 6-bit divide value makes the feedback tick, and a 4-bit divide value makes the reference tick. Each divider fires once every (value+1) input pulses.

A measurement window lasts a fixed number of reference ticks, 32 by default. The block counts feedback ticks during the window and compares the count with that same number. The window is timed by the reference, so the status updates more often when the reference is faster. The status has hysteresis. It enters lock only when the error is within a tight band (±1 by default). It leaves lock only when the error goes beyond a wider band (±3 by default).

Every change of the lock bit, whether it sets or clears, raises a sticky change flag. Writing 1 to the flag clears it. The interrupt request is the flag ANDed with an enable bit. Writing either divide value restarts the measurement and forces the lock bit to 0.

Top module: `freq_lock_det`

## Requirements
- R1: The feedback tick fires once every (F+1) feedback-edge pulses, where F is the 6-bit feedback divide value.
- R2: The reference tick fires once every (D+1) reference-edge pulses, where D is the 4-bit reference divide value.
- R3: A window closes after 32 reference ticks, so the time until the lock bit first updates scales with the reference tick period.
- R4: While unlocked, a window whose feedback-tick count is within ±1 of 32 sets the lock bit.
- R5: While locked, the lock bit stays 1 for counts within ±3 of 32 and clears when a count lies outside ±3.
- R6: While unlocked, a count whose error is 2 or more leaves the lock bit at 0.
- R7: A write to either divide value restarts the window and makes the lock bit 0 on the next cycle.
- R8: After reset the lock bit, change flag, enable and interrupt request are all 0.
- R9: Every change of the lock bit, including a forced clear, sets the sticky change flag. Writing 1 clears it, and writing 0 leaves it unchanged.
- R10: The interrupt request equals the change flag ANDed with the enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vco_pulse | input | 1 | One-cycle pulse per feedback source edge |
| src_pulse | input | 1 | One-cycle pulse per reference source edge |
| fb_div_wr | input | 1 | Write strobe for the feedback divide value |
| fb_div_data | input | 6 | Feedback divide value F |
| ref_div_wr | input | 1 | Write strobe for the reference divide value |
| ref_div_data | input | 4 | Reference divide value D |
| ie_wr | input | 1 | Write strobe for the interrupt enable |
| ie_data | input | 1 | Interrupt enable value |
| flag_wr | input | 1 | Write strobe for the change flag |
| flag_data | input | 1 | Writing 1 clears the change flag |
| lock_o | output | 1 | Lock status, read-only |
| chg_flag_o | output | 1 | Sticky lock-change flag |
| ie_o | output | 1 | Interrupt enable register |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:
- lock is entered only right after a window whose error was within the tight band;
- lock is left only after a window beyond the wide band, or after a restart;
- every change of the lock bit leaves the flag set;
- the flag stays set until a write of 1;
- a divider write always leaves the lock bit at 0.

Some behaviours only the bench's scenarios can show. These are the correct divide ratios across the swept settings, the window rate scaling with the reference period, and the staying locked inside the wide band. Also in this group are the staying unlocked just outside the tight band and the interrupt gating by the enable.

// File: rtl/flock_pkg.sv
// Shared types and helpers for the frequency lock detector.
package flock_pkg;

    // Hysteresis state of the lock decision
    typedef enum logic {
        ST_UNLOCKED = 1'b0,
        ST_LOCKED   = 1'b1
    } lock_state_e;

    // Larger of two integers, used to keep the exit band no narrower than the entry band
    function automatic int wider_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/flock_pulse_div.sv
// Pulse divider: emits one registered tick for every (div_i+1) input pulses.
// Assumes pulse_i is already synchronous and at most one cycle wide.
// restart clears the count so a new divide value takes effect from a clean phase.
module flock_pulse_div #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             pulse_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt_q;

    // Count input pulses and fire a tick when the terminal count is reached
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else if (restart) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else begin
            tick_o <= 1'b0;
            if (pulse_i) begin
                if (cnt_q == div_i) begin
                    cnt_q  <= '0;
                    tick_o <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/flock_window.sv
// Measurement window: counts feedback ticks over WIN_LEN reference ticks.
// At the closing reference tick it presents the count for one cycle with
// meas_valid. The count saturates instead of wrapping. restart opens a fresh window.
module flock_window #(
    parameter int WIN_LEN = 32,
    parameter int CNT_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             ref_tick,
    input  logic             fb_tick,
    output logic             meas_valid,
    output logic [CNT_W-1:0] meas_cnt
);

    localparam int               REF_W    = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
    localparam logic [REF_W-1:0] REF_LAST = REF_W'(WIN_LEN - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;

    logic [REF_W-1:0] ref_cnt_q;
    logic [CNT_W-1:0] fb_cnt_q;
    logic [CNT_W-1:0] fb_cnt_next;

    // Saturating increment of the feedback count for this cycle
    always_comb begin
        fb_cnt_next = fb_cnt_q;
        if (fb_tick && (fb_cnt_q != CNT_MAX)) begin
            fb_cnt_next = fb_cnt_q + 1'b1;
        end
    end

    // Advance the window and publish the count when it closes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_cnt_q  <= '0;
            fb_cnt_q   <= '0;
            meas_valid <= 1'b0;
            meas_cnt   <= '0;
        end else if (restart) begin
            ref_cnt_q  <= '0;
            fb_cnt_q   <= '0;
            meas_valid <= 1'b0;
        end else begin
            meas_valid <= 1'b0;
            if (ref_tick && (ref_cnt_q == REF_LAST)) begin
                ref_cnt_q  <= '0;
                fb_cnt_q   <= '0;
                meas_valid <= 1'b1;
                meas_cnt   <= fb_cnt_next;
            end else begin
                if (ref_tick) begin
                    ref_cnt_q <= ref_cnt_q + 1'b1;
                end
                fb_cnt_q <= fb_cnt_next;
            end
        end
    end

endmodule

// File: rtl/flock_judge.sv
// Lock decision with hysteresis. Entry needs the error within LOCK_TOL.
// Exit needs the error beyond UNL_TOL. restart forces the unlocked state.
// toggle_o is high in the cycle whose clock edge changes lock_o.
module flock_judge #(
    parameter int WIN_LEN  = 32,
    parameter int CNT_W    = 8,
    parameter int LOCK_TOL = 1,
    parameter int UNL_TOL  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             meas_valid,
    input  logic [CNT_W-1:0] meas_cnt,
    output logic             lock_o,
    output logic             toggle_o
);

    import flock_pkg::*;

    localparam logic [CNT_W:0] WIN_C   = (CNT_W+1)'(WIN_LEN);
    localparam logic [CNT_W:0] ENTRY_C = (CNT_W+1)'(LOCK_TOL);
    localparam logic [CNT_W:0] EXIT_C  = (CNT_W+1)'(UNL_TOL);

    lock_state_e    state_q, state_d;
    logic [CNT_W:0] err;

    // Magnitude of the difference between the measured and expected counts
    always_comb begin
        if ({1'b0, meas_cnt} >= WIN_C) begin
            err = {1'b0, meas_cnt} - WIN_C;
        end else begin
            err = WIN_C - {1'b0, meas_cnt};
        end
    end

    // Next hysteresis state from the latest measurement
    always_comb begin
        state_d = state_q;
        if (restart) begin
            state_d = ST_UNLOCKED;
        end else if (meas_valid) begin
            case (state_q)
                ST_UNLOCKED: if (err <= ENTRY_C) state_d = ST_LOCKED;
                ST_LOCKED:   if (err >  EXIT_C)  state_d = ST_UNLOCKED;
                default:     state_d = ST_UNLOCKED;
            endcase
        end
    end

    // Hold the decision state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_UNLOCKED;
        end else begin
            state_q <= state_d;
        end
    end

    assign lock_o   = (state_q == ST_LOCKED);
    assign toggle_o = (state_d != state_q);

endmodule

// File: rtl/flock_irq.sv
// Change flag and interrupt gating. The flag sets on every lock toggle.
// A write of 1 clears it, and a toggle in the same cycle takes priority.
// The request is the flag gated by the enable register.
module flock_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic toggle_i,
    input  logic ie_wr,
    input  logic ie_data,
    input  logic flag_wr,
    input  logic flag_data,
    output logic flag_o,
    output logic ie_o,
    output logic irq_o
);

    // Sticky change flag with write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else if (toggle_i) begin
            flag_o <= 1'b1;
        end else if (flag_wr && flag_data) begin
            flag_o <= 1'b0;
        end
    end

    // Interrupt enable register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_o <= 1'b0;
        end else if (ie_wr) begin
            ie_o <= ie_data;
        end
    end

    assign irq_o = flag_o & ie_o;

endmodule

// File: rtl/freq_lock_det.sv
// Frequency lock detector top. It holds the divide values, divides both edge
// pulse streams, and measures feedback ticks per reference window.
// It then drives a hysteretic lock bit and a change interrupt.
// Assumes both pulse inputs are already synchronous to clk.
module freq_lock_det #(
    parameter int FB_DIV_W   = 6,
    parameter int REF_DIV_W  = 4,
    parameter int WIN_LEN    = 32,
    parameter int LOCK_TOL   = 1,
    parameter int UNLOCK_TOL = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 vco_pulse,
    input  logic                 src_pulse,
    input  logic                 fb_div_wr,
    input  logic [FB_DIV_W-1:0]  fb_div_data,
    input  logic                 ref_div_wr,
    input  logic [REF_DIV_W-1:0] ref_div_data,
    input  logic                 ie_wr,
    input  logic                 ie_data,
    input  logic                 flag_wr,
    input  logic                 flag_data,
    output logic                 lock_o,
    output logic                 chg_flag_o,
    output logic                 ie_o,
    output logic                 irq_o
);

    localparam int CNT_W   = $clog2(WIN_LEN * 4 + 1);
    localparam int UNL_EFF = flock_pkg::wider_of(UNLOCK_TOL, LOCK_TOL);

    logic [FB_DIV_W-1:0]  fb_div_q;
    logic [REF_DIV_W-1:0] ref_div_q;
    logic                 restart;
    logic                 fb_tick;
    logic                 ref_tick;
    logic                 meas_valid;
    logic [CNT_W-1:0]     meas_cnt;
    logic                 lock_toggle;

    assign restart = fb_div_wr | ref_div_wr;

    // Divide value registers written by software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fb_div_q  <= '0;
            ref_div_q <= '0;
        end else begin
            if (fb_div_wr)  fb_div_q  <= fb_div_data;
            if (ref_div_wr) ref_div_q <= ref_div_data;
        end
    end

    flock_pulse_div #(.DIV_W(FB_DIV_W)) u_fb_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .pulse_i (vco_pulse),
        .div_i   (fb_div_q),
        .tick_o  (fb_tick)
    );

    flock_pulse_div #(.DIV_W(REF_DIV_W)) u_ref_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .pulse_i (src_pulse),
        .div_i   (ref_div_q),
        .tick_o  (ref_tick)
    );

    flock_window #(.WIN_LEN(WIN_LEN), .CNT_W(CNT_W)) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .ref_tick   (ref_tick),
        .fb_tick    (fb_tick),
        .meas_valid (meas_valid),
        .meas_cnt   (meas_cnt)
    );

    flock_judge #(
        .WIN_LEN  (WIN_LEN),
        .CNT_W    (CNT_W),
        .LOCK_TOL (LOCK_TOL),
        .UNL_TOL  (UNL_EFF)
    ) u_judge (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .meas_valid (meas_valid),
        .meas_cnt   (meas_cnt),
        .lock_o     (lock_o),
        .toggle_o   (lock_toggle)
    );

    flock_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .toggle_i  (lock_toggle),
        .ie_wr     (ie_wr),
        .ie_data   (ie_data),
        .flag_wr   (flag_wr),
        .flag_data (flag_data),
        .flag_o    (chg_flag_o),
        .ie_o      (ie_o),
        .irq_o     (irq_o)
    );

endmodule

// File: rtl/flock_checker.sv
// Temporal checks on the lock detector, bound to the top module.
module flock_checker #(
    parameter int WIN_LEN  = 32,
    parameter int CNT_W    = 8,
    parameter int LOCK_TOL = 1,
    parameter int UNL_TOL  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             restart,
    input logic             meas_valid,
    input logic [CNT_W-1:0] meas_cnt,
    input logic             lock_o,
    input logic             chg_flag_o,
    input logic             flag_wr,
    input logic             flag_data,
    input logic             ie_o,
    input logic             irq_o
);

    int chk_err;

    // Independent error magnitude of the published measurement
    always_comb begin
        chk_err = int'(meas_cnt) - WIN_LEN;
        if (chk_err < 0) chk_err = -chk_err;
    end

    AST_RESTART_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !lock_o); // R7

    AST_TOGGLE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_o != $past(lock_o)) |-> chg_flag_o); // R9

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_flag_o && !(flag_wr && flag_data)) |=> chg_flag_o); // R9

    AST_ENTRY_TIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> ($past(meas_valid) && ($past(chk_err) <= LOCK_TOL))); // R4

    AST_EXIT_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(lock_o) && !$past(restart)) |-> ($past(meas_valid) && ($past(chk_err) > UNL_TOL))); // R5

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (ie_o && chg_flag_o)); // R10

endmodule

bind freq_lock_det flock_checker #(
    .WIN_LEN  (WIN_LEN),
    .CNT_W    (CNT_W),
    .LOCK_TOL (LOCK_TOL),
    .UNL_TOL  (UNL_EFF)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .meas_valid (meas_valid),
    .meas_cnt   (meas_cnt),
    .lock_o     (lock_o),
    .chg_flag_o (chg_flag_o),
    .flag_wr    (flag_wr),
    .flag_data  (flag_data),
    .ie_o       (ie_o),
    .irq_o      (irq_o)
);

// File: tb/tb_freq_lock_det.sv
module tb_freq_lock_det;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vco_pulse = 1'b0;
    logic       src_pulse = 1'b0;
    logic       fb_div_wr = 1'b0;
    logic [5:0] fb_div_data = '0;
    logic       ref_div_wr = 1'b0;
    logic [3:0] ref_div_data = '0;
    logic       ie_wr = 1'b0;
    logic       ie_data = 1'b0;
    logic       flag_wr = 1'b0;
    logic       flag_data = 1'b0;
    logic       lock_o, chg_flag_o, ie_o, irq_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // Stimulus generator state: the feedback source is an NCO over WIN_CYC cycles
    bit gen_on = 0;
    int vco_num = 0;
    int vco_acc = 0;
    int src_per = 8;
    int src_ctr = 0;
    int win_cyc = 256;

    always #2.5 clk = ~clk;

    freq_lock_det dut (
        .clk(clk), .rst_n(rst_n), .vco_pulse(vco_pulse), .src_pulse(src_pulse),
        .fb_div_wr(fb_div_wr), .fb_div_data(fb_div_data),
        .ref_div_wr(ref_div_wr), .ref_div_data(ref_div_data),
        .ie_wr(ie_wr), .ie_data(ie_data), .flag_wr(flag_wr), .flag_data(flag_data),
        .lock_o(lock_o), .chg_flag_o(chg_flag_o), .ie_o(ie_o), .irq_o(irq_o)
    );

    // Pulse generation away from the active edge
    always @(negedge clk) begin
        if (gen_on) begin
            vco_acc = vco_acc + vco_num;
            if (vco_acc >= win_cyc) begin
                vco_acc = vco_acc - win_cyc;
                vco_pulse = 1'b1;
            end else begin
                vco_pulse = 1'b0;
            end
            src_ctr = src_ctr + 1;
            if (src_ctr >= src_per) begin
                src_ctr = 0;
                src_pulse = 1'b1;
            end else begin
                src_pulse = 1'b0;
            end
        end else begin
            vco_pulse = 1'b0;
            src_pulse = 1'b0;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Feedback rate giving an ideal count n per window for divide value s
    task automatic set_count(input int n, input int s);
        vco_num = n * (s + 1);
    endtask

    task automatic wr_div(input int s, input int r);
        @(negedge clk);
        fb_div_wr = 1'b1; fb_div_data = 6'(s);
        ref_div_wr = 1'b1; ref_div_data = 4'(r);
        @(negedge clk);
        fb_div_wr = 1'b0; ref_div_wr = 1'b0;
    endtask

    task automatic wr_ie(input logic v);
        @(negedge clk);
        ie_wr = 1'b1; ie_data = v;
        @(negedge clk);
        ie_wr = 1'b0;
    endtask

    task automatic wr_flag(input logic v);
        @(negedge clk);
        flag_wr = 1'b1; flag_data = v;
        @(negedge clk);
        flag_wr = 1'b0; flag_data = 1'b0;
    endtask

    task automatic run_windows(input int n);
        repeat (n * win_cyc + 40) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 lock after reset", lock_o, 1'b0);
        chk("R8 flag after reset", chg_flag_o, 1'b0);
        chk("R8 enable after reset", ie_o, 1'b0);
        chk("R8 irq after reset", irq_o, 1'b0);

        gen_on = 1;
        wr_ie(1'b1);

        // Sweep: reference period (src_per*(r+1)) kept at 8 cycles, feedback divide 0..5
        for (int ri = 0; ri < 4; ri++) begin
            for (int s = 0; s < 6; s++) begin
                int r;
                r = (1 << ri) - 1;
                src_per = 8 >> ri;
                set_count(32, s);
                wr_div(s, r);
                wr_flag(1'b1);
                run_windows(4);
                chk($sformatf("R1 R2 R4 lock s=%0d r=%0d", s, r), lock_o, 1'b1);
                chk("R9 flag after lock entry", chg_flag_o, 1'b1);
                chk("R10 irq with enable", irq_o, 1'b1);
                set_count(40, s);
                run_windows(3);
                chk($sformatf("R5 drop at err 8 s=%0d r=%0d", s, r), lock_o, 1'b0);
            end
        end

        // R3: a reference period of 16 cycles doubles the window length
        src_per = 4; win_cyc = 512; vco_acc = 0;
        set_count(32, 3);
        wr_div(3, 3);
        repeat (400) @(negedge clk);
        chk("R3 no decision before long window closes", lock_o, 1'b0);
        repeat (700) @(negedge clk);
        chk("R3 lock after long window", lock_o, 1'b1);

        // Hysteresis scenarios with window of 256 cycles
        src_per = 4; win_cyc = 256; vco_acc = 0;
        set_count(32, 3);
        wr_div(3, 1);
        run_windows(3);
        chk("R4 lock at 32", lock_o, 1'b1);
        wr_flag(1'b1);
        set_count(34, 3);
        run_windows(4);
        chk("R5 stays locked at err 2", lock_o, 1'b1);
        chk("R9 no toggle inside band", chg_flag_o, 1'b0);
        set_count(38, 3);
        run_windows(3);
        chk("R5 drops at err 6", lock_o, 1'b0);
        chk("R9 flag on clear", chg_flag_o, 1'b1);
        wr_flag(1'b0);
        chk("R9 write 0 ignored", chg_flag_o, 1'b1);
        wr_flag(1'b1);
        chk("R9 write 1 clears", chg_flag_o, 1'b0);

        wr_ie(1'b0);
        set_count(35, 3);
        run_windows(4);
        chk("R6 no entry at err 3", lock_o, 1'b0);
        chk("R6 no toggle", chg_flag_o, 1'b0);
        set_count(33, 3);
        run_windows(3);
        chk("R4 entry at err 1", lock_o, 1'b1);
        chk("R10 flag set", chg_flag_o, 1'b1);
        chk("R10 irq masked", irq_o, 1'b0);
        wr_ie(1'b1);
        chk("R10 irq follows enable", irq_o, 1'b1);
        wr_flag(1'b1);
        set_count(27, 3);
        run_windows(3);
        chk("R5 drop at err 5 low side", lock_o, 1'b0);

        // R7: divider writes force lock low and count as a toggle
        set_count(32, 3);
        run_windows(3);
        chk("R7 relock", lock_o, 1'b1);
        wr_flag(1'b1);
        @(negedge clk);
        fb_div_wr = 1'b1; fb_div_data = 6'd3;
        @(negedge clk);
        fb_div_wr = 1'b0;
        chk("R7 lock cleared by feedback write", lock_o, 1'b0);
        chk("R7 R9 forced clear flags", chg_flag_o, 1'b1);
        run_windows(3);
        chk("R7 relock after restart", lock_o, 1'b1);
        @(negedge clk);
        ref_div_wr = 1'b1; ref_div_data = 4'd1;
        @(negedge clk);
        ref_div_wr = 1'b0;
        chk("R7 lock cleared by reference write", lock_o, 1'b0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (150000) @(negedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule